// File: doc/BRIEF.md
# Small-Page NAND Command and Address Front End

This block is the device-side front end of a byte-wide, small-page NAND flash. On each write strobe it samples an 8-bit bus. When the command latch is high, the byte is a command. When the address latch is high, the byte is an address. From these cycles it keeps a read mode, a half-page pointer, a column pointer and a row address. On read strobes it returns one of three things: a stand-in page byte, the four identification bytes, or the status byte. A down-counter, loaded with a parameterised number of clock cycles, stands in for the array's internal busy time. The ready output is high whenever that counter is zero.

A page has 528 bytes: 512 data bytes followed by 16 spare bytes at columns 512 to 527. There are three pointer commands, and each one picks the region of the page that the first address byte indexes. The pointer to the second half of the data is used for only one page-read address sequence. After that sequence the pointer drops back to the first half by itself. The cell array is not part of this block. A page byte read back is the low 8 bits of the column XOR the low 8 bits of the row, so a bench can compute the expected data.

Top module: `nand_cmd_front`

## Requirements
- R1: After reset, ready is 1, ptr_area is 0 (first half), col_ptr is 0, dout_vld is 0 and the mode is page read.
- R2: Command 00h sets ptr_area to 0, 01h sets it to 1 and 50h sets it to 2. The first address byte b then loads col_ptr with b, with 256+b, or with 512+b[3:0], depending on the area.
- R3: In page-read mode the second, third and fourth address bytes are row bits 7:0, 15:8 and 23:16. row_addr shows the low ROW_W bits of these. The fourth address byte starts a busy period, and a further address byte begins a new column byte.
- R4: When a fourth address byte is accepted while ptr_area is 1, ptr_area becomes 0. A later address sequence with no new command then uses base 0.
- R5: In page-read mode, with a page loaded and ready high, each read strobe puts col_ptr[7:0] XOR row_addr[7:0] on dout. dout_vld is high in the next cycle. col_ptr then advances by one, but it holds at 527.
- R6: Command 90h followed by one address byte enters identification mode. Successive read strobes then return ECh, 76h, A5h and C0h, and the sequence repeats.
- R7: Command 70h is accepted even while busy. Each read strobe after it returns the status byte: bit 7 is 1, bit 6 is ready, and the other bits are 0. This gives C0h when ready and 80h when busy.
- R8: Command FFh is accepted at any time and aborts a busy read. It holds ready low for exactly T_RST cycles, sets the mode to page read and ptr_area to 0, and unloads the page. A page read strobe then gives no dout_vld.
- R9: A write strobe is ignored if sel_n is high or if both latches are high. While busy, every command except 70h and FFh is ignored, and so is every address byte.
- R10: A command byte outside 00h, 01h, 50h, 70h, 90h and FFh leaves the mode, the pointer, the column and the row unchanged.
- R11: After the fourth page-read address byte, ready stays low for exactly T_RD cycles and then returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel_n | input | 1 | Active-low chip select |
| cmd_lat | input | 1 | Marks a write strobe as a command |
| adr_lat | input | 1 | Marks a write strobe as an address |
| wr_stb | input | 1 | One-cycle write strobe |
| rd_stb | input | 1 | One-cycle read strobe |
| din | input | 8 | Bus byte sampled on a write strobe |
| dout | output | 8 | Byte returned for the last accepted read |
| dout_vld | output | 1 | High for one cycle after an accepted read |
| ready | output | 1 | High when no busy period is running |
| ptr_area | output | 2 | Half-page pointer: 0 first half, 1 second half, 2 spare |
| col_ptr | output | 10 | Current column, 0 to 527 |
| row_addr | output | ROW_W | Latched row address |

## Verification
The assertions assume the following about the inputs. Strobes are single-cycle. Read and write strobes never fall in the same cycle. The row width does not exceed 24 bits. The stimulus keeps to this: each bench task raises exactly one strobe for one clock and then leaves a quiet cycle. All inputs change on the falling edge. The bench does send the cycles that break the protocol (a deselected chip, both latches high, an unknown command, commands during busy), but always as single clean strobes, so that the checks that the state is unchanged stay meaningful.

// File: rtl/nand_cmd_front.sv
module nand_cmd_front #(
  parameter int ROW_W = 17,
  parameter int T_RD  = 25,
  parameter int T_RST = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             cmd_lat,
  input  logic             adr_lat,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic [7:0]       din,
  output logic [7:0]       dout,
  output logic             dout_vld,
  output logic             ready,
  output logic [1:0]       ptr_area,
  output logic [9:0]       col_ptr,
  output logic [ROW_W-1:0] row_addr
);
  localparam int TMAX   = (T_RD > T_RST) ? T_RD : T_RST;
  localparam int CNT_W  = $clog2(TMAX + 1);
  localparam logic [9:0] COL_LAST = 10'd527;

  typedef enum logic [1:0] {M_READ, M_ID, M_STAT} mode_t;

  mode_t       mode_q;
  logic [1:0]  area_q;
  logic [9:0]  col_q;
  logic [23:0] row_q;
  logic [1:0]  adr_cnt;
  logic        page_ok, id_armed;
  logic [1:0]  id_idx;
  logic [CNT_W-1:0] busy_cnt;

  wire busy    = busy_cnt != '0;
  wire wr_ok   = wr_stb && !sel_n && !(cmd_lat && adr_lat);
  wire cmd_cyc = wr_ok && cmd_lat;
  wire adr_cyc = wr_ok && adr_lat;
  wire is_ptr  = din == 8'h00 || din == 8'h01 || din == 8'h50;
  wire cmd_take = cmd_cyc && (din == 8'hFF || din == 8'h70 ||
                              (!busy && (is_ptr || din == 8'h90)));
  wire rd_ok = rd_stb && !sel_n &&
               (mode_q == M_STAT || (mode_q == M_ID && id_armed) ||
                (mode_q == M_READ && page_ok && !busy));

  logic [9:0] col_base;
  always_comb begin
    case (area_q)
      2'd1:    col_base = {2'b01, din};
      2'd2:    col_base = {2'b10, 4'b0000, din[3:0]};
      default: col_base = {2'b00, din};
    endcase
  end

  logic [7:0] id_byte;
  always_comb begin
    case (id_idx)
      2'd0: id_byte = 8'hEC;
      2'd1: id_byte = 8'h76;
      2'd2: id_byte = 8'hA5;
      default: id_byte = 8'hC0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_READ;
      area_q   <= 2'd0;
      col_q    <= '0;
      row_q    <= '0;
      adr_cnt  <= '0;
      page_ok  <= 1'b0;
      id_armed <= 1'b0;
      id_idx   <= '0;
      busy_cnt <= '0;
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= rd_ok;
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (cmd_take) begin
        case (din)
          8'hFF: begin
            mode_q   <= M_READ;
            area_q   <= 2'd0;
            adr_cnt  <= '0;
            page_ok  <= 1'b0;
            id_armed <= 1'b0;
            busy_cnt <= CNT_W'(T_RST);
          end
          8'h70: mode_q <= M_STAT;
          8'h90: begin
            mode_q   <= M_ID;
            id_armed <= 1'b0;
            id_idx   <= '0;
            adr_cnt  <= '0;
          end
          8'h01: begin mode_q <= M_READ; area_q <= 2'd1; adr_cnt <= '0; end
          8'h50: begin mode_q <= M_READ; area_q <= 2'd2; adr_cnt <= '0; end
          default: begin mode_q <= M_READ; area_q <= 2'd0; adr_cnt <= '0; end
        endcase
      end else if (adr_cyc && !busy) begin
        if (mode_q == M_ID) begin
          id_armed <= 1'b1;
          id_idx   <= '0;
        end else if (mode_q == M_READ) begin
          adr_cnt <= adr_cnt + 1'b1;
          case (adr_cnt)
            2'd0: begin col_q <= col_base; page_ok <= 1'b0; end
            2'd1: row_q[7:0]   <= din;
            2'd2: row_q[15:8]  <= din;
            default: begin
              row_q[23:16] <= din;
              page_ok      <= 1'b1;
              busy_cnt     <= CNT_W'(T_RD);
              if (area_q == 2'd1) area_q <= 2'd0;
            end
          endcase
        end
      end
      if (rd_ok) begin
        case (mode_q)
          M_READ: begin
            dout <= col_q[7:0] ^ row_q[7:0];
            if (col_q != COL_LAST) col_q <= col_q + 1'b1;
          end
          M_ID: begin
            dout   <= id_byte;
            id_idx <= id_idx + 1'b1;
          end
          default: dout <= {1'b1, ready, 6'b0};
        endcase
      end
    end
  end

  assign ready    = !busy;
  assign ptr_area = area_q;
  assign col_ptr  = col_q;
  assign row_addr = row_q[ROW_W-1:0];

  a_r9_ignored_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !rd_stb && (sel_n || (cmd_lat && adr_lat)))
      |=> ($stable(ptr_area) && $stable(col_ptr) && $stable(row_addr)));

  a_r11_ready_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cnt == CNT_W'(1) && !cmd_take) |=> ready);

  a_r4_pointer_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_cyc && !busy && mode_q == M_READ && adr_cnt == 2'd3 && area_q == 2'd1)
      |=> ptr_area == 2'd0);

  a_r5_col_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    col_ptr <= COL_LAST);

  a_r5_vld_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    dout_vld |-> $past(rd_stb));

  a_r7_status_ready_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && mode_q == M_STAT) |=> (dout[6] == $past(ready) && dout[7]));

  a_r8_reset_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_take && din == 8'hFF) |=> (!ready && ptr_area == 2'd0));
endmodule

// File: tb/nand_cmd_front_test.sv
`timescale 1ns/1ps
module nand_cmd_front_test;
  localparam int ROW_W = 17;
  localparam int T_RD  = 12;
  localparam int T_RST = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b0, cmd_lat = 1'b0, adr_lat = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_vld, ready;
  logic [1:0] ptr_area;
  logic [9:0] col_ptr;
  logic [ROW_W-1:0] row_addr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  nand_cmd_front #(.ROW_W(ROW_W), .T_RD(T_RD), .T_RST(T_RST)) uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .cmd_lat(cmd_lat), .adr_lat(adr_lat),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .din(din), .dout(dout), .dout_vld(dout_vld),
    .ready(ready), .ptr_area(ptr_area), .col_ptr(col_ptr), .row_addr(row_addr));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && dout_vld) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R5/R8 unexpected output: actual %0h expected none", dout);
      end else begin
        automatic string t = tag_q.pop_front();
        check(t, dout, exp_q.pop_front());
      end
    end
  end

  task automatic wr(bit c, bit a, logic [7:0] b, bit desel = 0);
    @(negedge clk);
    cmd_lat = c; adr_lat = a; din = b; sel_n = desel; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; cmd_lat = 1'b0; adr_lat = 1'b0; sel_n = 1'b0;
  endtask

  task automatic cmd(logic [7:0] b); wr(1, 0, b); endtask
  task automatic adr(logic [7:0] b); wr(0, 1, b); endtask

  task automatic rd(bit expect_out, logic [7:0] e, string req);
    @(negedge clk);
    if (expect_out) begin exp_q.push_back(e); tag_q.push_back(req); end
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    if (!expect_out) check({req, " no output"}, dout_vld, 0);
  endtask

  task automatic wait_ready(string req, int exp_cycles);
    int cnt = 0;
    while (!ready && cnt < 1000) begin @(negedge clk); cnt++; end
    check(req, cnt, exp_cycles);
  endtask

  function automatic logic [7:0] pbyte(int col, int row);
    return 8'(col) ^ 8'(row);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready", ready, 1);
    check("R1 area", ptr_area, 0);
    check("R1 col", col_ptr, 0);
    check("R1 vld", dout_vld, 0);
    rd(0, 0, "R1 read before address");

    // R2/R3/R11 first-half read
    cmd(8'h00); adr(8'h10); adr(8'h34); adr(8'h12); adr(8'h01);
    check("R2 col area A", col_ptr, 10'h010);
    check("R3 row", row_addr, 17'h11234);
    check("R3 busy", ready, 0);
    wait_ready("R11 read busy cycles", T_RD);
    rd(1, pbyte(16, 8'h34), "R5 read0");
    rd(1, pbyte(17, 8'h34), "R5 read1");
    rd(1, pbyte(18, 8'h34), "R5 read2");

    // R2/R4 second-half pointer and fallback
    cmd(8'h01);
    check("R2 area B", ptr_area, 1);
    adr(8'h05);
    check("R2 col area B", col_ptr, 10'h105);
    adr(8'h02); adr(8'h00); adr(8'h00);
    check("R4 fallback", ptr_area, 0);
    wait_ready("R11 second busy", T_RD);
    rd(1, pbyte(16'h105, 2), "R5 read area B");
    adr(8'h05); adr(8'h03); adr(8'h00); adr(8'h00);
    check("R4 next sequence base 0", col_ptr, 10'h005);
    wait_ready("R3 third busy", T_RD);
    rd(1, pbyte(5, 3), "R4 read after fallback");

    // R2/R5 spare area and end of page
    cmd(8'h50);
    adr(8'h0E); adr(8'h07); adr(8'h00); adr(8'h00);
    check("R2 col area C", col_ptr, 10'h20E);
    wait_ready("R3 spare busy", T_RD);
    rd(1, pbyte(10'h20E, 7), "R5 spare0");
    rd(1, pbyte(10'h20F, 7), "R5 spare1");
    check("R5 col hold", col_ptr, 527);
    rd(1, pbyte(10'h20F, 7), "R5 hold at last");
    check("R2 area C kept", ptr_area, 2);

    // R10 unknown command
    cmd(8'h3C);
    check("R10 area", ptr_area, 2);
    check("R10 col", col_ptr, 527);
    rd(1, pbyte(10'h20F, 7), "R10 mode kept");

    // R9 ignored cycles
    wr(1, 0, 8'h00, 1);
    check("R9 deselected", ptr_area, 2);
    wr(1, 1, 8'h01);
    check("R9 both latches", ptr_area, 2);
    check("R9 both latches col", col_ptr, 527);

    // R7 status ready
    cmd(8'h70);
    rd(1, 8'hC0, "R7 status ready");

    // R7/R9/R8 busy handling
    cmd(8'h00); adr(8'h20); adr(8'h40); adr(8'h00); adr(8'h00);
    cmd(8'h70);
    rd(1, 8'h80, "R7 status busy");
    cmd(8'h01);
    check("R9 busy cmd ignored", ptr_area, 0);
    adr(8'h99);
    check("R9 busy addr ignored", col_ptr, 10'h020);
    cmd(8'hFF);
    check("R8 reset busy", ready, 0);
    check("R8 area", ptr_area, 0);
    wait_ready("R8 reset cycles", T_RST);
    rd(0, 0, "R8 page unloaded");

    // R6 identification
    cmd(8'h90); adr(8'h00);
    rd(1, 8'hEC, "R6 id0");
    rd(1, 8'h76, "R6 id1");
    rd(1, 8'hA5, "R6 id2");
    rd(1, 8'hC0, "R6 id3");
    rd(1, 8'hEC, "R6 id wrap");

    // R8 reset when ready
    cmd(8'hFF);
    wait_ready("R8 reset from ready", T_RST);

    repeat (3) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule